// File: doc/BRIEF.md
# ALU with Output Shifter

This block is the arithmetic stage of a microcoded datapath. It takes two 32-bit operands from the operand buses and a 9-bit control word from the current microinstruction. In the same cycle it produces one result, which goes to the write-back bus. Each operand can be gated to zero on its own. Operand A can be inverted, and a carry-in of one can be added. A function selector picks one of eight functions. Alongside the logic and add functions are single-cycle signed multiply, divide and remainder.

The function result then passes through a shifter. The shifter can leave it as it is, move it right by one bit, move it left by one bit, or move it left by a whole byte so that a byte lands in the next byte lane. Two flags, zero and negative, describe the function result before it is shifted. The sequencer uses these flags for its conditional branches. Choosing which registers drive the operand buses, and which registers take the result, is done outside this block.

Top module: `alu_shift_unit`

## Requirements
- R1: Function code `fn` = ctrl[6:4] selects, on the conditioned operands: 000 bitwise AND, 001 bitwise OR, 010 bitwise NOT of B, 011 sum A+B, 100 bitwise XOR.
- R2: Function code 101 returns the low 32 bits of the product A*B.
- R3: Function code 110 returns the signed quotient A/B, rounded toward zero. Function code 111 returns the signed remainder, which takes the sign of the dividend.
- R4: With a zero divisor, the quotient is all ones and the remainder equals the dividend.
- R5: Dividing the most negative value (0x80000000) by −1 gives a quotient of 0x80000000 and a remainder of 0.
- R6: When enable-A (ctrl[3]) is 0, operand A is taken as 0. When enable-B (ctrl[2]) is 0, operand B is taken as 0.
- R7: When invert-A (ctrl[1]) is 1, operand A is inverted after the enable is applied. With enable-A at 0, operand A is therefore all ones.
- R8: When increment (ctrl[0]) is 1, one is added modulo 2^32 to the function result, for every function code.
- R9: Shift code ctrl[8:7] acts on the function result: 00 passes it unchanged, 01 shifts it logically right by 1, 10 shifts it left by 8, 11 shifts it left by 1. Vacated bits are filled with 0.
- R10: The control word is laid out from MSB to LSB as shift code (2 bits), function code (3 bits), enable-A, enable-B, invert-A, increment.
- R11: `zero_o` is 1 exactly when the function result, before shifting, is 0.
- R12: `neg_o` equals bit 31 of the function result before shifting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctrl_i | input | 9 | Control word: shift code, function code, enables, invert, increment |
| opa_i | input | 32 | Operand A bus |
| opb_i | input | 32 | Operand B bus |
| shift_o | output | 32 | Shifted result, to the write-back bus |
| zero_o | output | 1 | Function result before the shift is zero |
| neg_o | output | 1 | Sign bit of the function result before the shift |

## Verification
The bench builds the unit with the default parameters: a 32-bit data width and a byte shift of 8. At this width the signed corner values fall within reach of directed vectors: 0x80000000, −1, 0 and 0x7FFFFFFF. Directed vectors cover the overflowing division, the zero divisor, the wrap of the increment past all ones, and shifts that push the only set bit out of the word while the flags still see it. A random phase then runs every control word over a mix of corner and random operands, and compares each result against an independently written model.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

  localparam int CTRL_W = 9;

  typedef enum logic [2:0] {
    FN_AND  = 3'b000,
    FN_OR   = 3'b001,
    FN_NOTB = 3'b010,
    FN_ADD  = 3'b011,
    FN_XOR  = 3'b100,
    FN_MUL  = 3'b101,
    FN_DIV  = 3'b110,
    FN_REM  = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_PASS   = 2'b00,
    SH_RIGHT1 = 2'b01,
    SH_LEFTB  = 2'b10,
    SH_LEFT1  = 2'b11
  } shift_e;

  typedef struct packed {
    shift_e  sh;
    alu_fn_e fn;
    logic    en_a;
    logic    en_b;
    logic    inv_a;
    logic    inc;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import alu_shift_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output alu_ctrl_t         dec_o
);
  // R10: field positions of the control word
  always_comb begin
    dec_o.sh    = shift_e'(ctrl_i[8:7]);
    dec_o.fn    = alu_fn_e'(ctrl_i[6:4]);
    dec_o.en_a  = ctrl_i[3];
    dec_o.en_b  = ctrl_i[2];
    dec_o.inv_a = ctrl_i[1];
    dec_o.inc   = ctrl_i[0];
  end
endmodule

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             en_a_i,
  input  logic             en_b_i,
  input  logic             inv_a_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] b_o
);
  logic [WIDTH-1:0] a_gated;

  always_comb begin
    a_gated = en_a_i ? opa_i : '0;          // R6
    a_o     = inv_a_i ? ~a_gated : a_gated; // R7
    b_o     = en_b_i ? opb_i : '0;          // R6
  end
endmodule

// File: rtl/alu_sdiv.sv
module alu_sdiv #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic signed [WIDTH-1:0] s_dvd;
  logic signed [WIDTH-1:0] s_dvs;

  always_comb begin
    s_dvd = $signed(dividend_i);
    s_dvs = $signed(divisor_i);
    if (divisor_i == '0) begin
      // R4: defined result for a zero divisor
      quo_o = '1;
      rem_o = dividend_i;
    end else if (dividend_i == MOST_NEG && divisor_i == '1) begin
      // R5: overflowing quotient wraps to the most negative value
      quo_o = MOST_NEG;
      rem_o = '0;
    end else begin
      quo_o = $unsigned(s_dvd / s_dvs);
      rem_o = $unsigned(s_dvd % s_dvs);
    end
  end
endmodule

// File: rtl/alu_func_core.sv
module alu_func_core
  import alu_shift_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_fn_e          fn_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] res_o
);
  logic [WIDTH-1:0] prod;
  logic [WIDTH-1:0] quo;
  logic [WIDTH-1:0] rem;
  logic [WIDTH-1:0] raw;

  alu_sdiv #(.WIDTH(WIDTH)) u_sdiv (
    .dividend_i (a_i),
    .divisor_i  (b_i),
    .quo_o      (quo),
    .rem_o      (rem)
  );

  always_comb begin
    prod = a_i * b_i; // R2: low half of the product
    unique case (fn_i)
      FN_AND:  raw = a_i & b_i;
      FN_OR:   raw = a_i | b_i;
      FN_NOTB: raw = ~b_i;
      FN_ADD:  raw = a_i + b_i;
      FN_XOR:  raw = a_i ^ b_i;
      FN_MUL:  raw = prod;
      FN_DIV:  raw = quo;
      FN_REM:  raw = rem;
      default: raw = '0;
    endcase
    res_o = raw + {{(WIDTH-1){1'b0}}, inc_i}; // R8
  end
endmodule

// File: rtl/alu_out_shifter.sv
module alu_out_shifter
  import alu_shift_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int BYTE_SHIFT = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  shift_e           sh_i,
  output logic [WIDTH-1:0] y_o
);
  // R9
  always_comb begin
    unique case (sh_i)
      SH_PASS:   y_o = x_i;
      SH_RIGHT1: y_o = x_i >> 1;
      SH_LEFTB:  y_o = x_i << BYTE_SHIFT;
      SH_LEFT1:  y_o = x_i << 1;
      default:   y_o = x_i;
    endcase
  end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_shift_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int BYTE_SHIFT = 8
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [WIDTH-1:0]  opa_i,
  input  logic [WIDTH-1:0]  opb_i,
  output logic [WIDTH-1:0]  shift_o,
  output logic              zero_o,
  output logic              neg_o
);
  alu_ctrl_t        dec;
  logic [WIDTH-1:0] a_c;
  logic [WIDTH-1:0] b_c;
  logic [WIDTH-1:0] alu_res;

  alu_ctrl_decode u_dec (
    .ctrl_i (ctrl_i),
    .dec_o  (dec)
  );

  alu_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .en_a_i  (dec.en_a),
    .en_b_i  (dec.en_b),
    .inv_a_i (dec.inv_a),
    .a_o     (a_c),
    .b_o     (b_c)
  );

  alu_func_core #(.WIDTH(WIDTH)) u_core (
    .a_i   (a_c),
    .b_i   (b_c),
    .fn_i  (dec.fn),
    .inc_i (dec.inc),
    .res_o (alu_res)
  );

  alu_out_shifter #(.WIDTH(WIDTH), .BYTE_SHIFT(BYTE_SHIFT)) u_shift (
    .x_i  (alu_res),
    .sh_i (dec.sh),
    .y_o  (shift_o)
  );

  // R11, R12: flags describe the unshifted result
  always_comb begin
    zero_o = (alu_res == '0);
    neg_o  = alu_res[WIDTH-1];
  end
endmodule

// File: rtl/alu_shift_unit_chk.sv
module alu_shift_unit_chk #(
  parameter int WIDTH      = 32,
  parameter int BYTE_SHIFT = 8
) (
  input logic [8:0]       ctrl_i,
  input logic [WIDTH-1:0] shift_o,
  input logic             zero_o,
  input logic             neg_o
);
  logic [1:0] sh;
  logic [2:0] fn;

  always_comb begin
    sh = ctrl_i[8:7];
    fn = ctrl_i[6:4];
    if (sh == 2'b00) begin
      a_r11_zero_matches_pass: assert (zero_o == (shift_o == '0))
        else $error("R11 zero flag disagrees with unshifted output");
      a_r12_neg_matches_pass: assert (neg_o == shift_o[WIDTH-1])
        else $error("R12 negative flag disagrees with unshifted output");
    end
    if (sh == 2'b01) begin
      a_r9_right_fills_msb: assert (!shift_o[WIDTH-1])
        else $error("R9 right shift left MSB set");
    end
    if (sh == 2'b10) begin
      a_r9_byte_fills_low: assert (shift_o[BYTE_SHIFT-1:0] == '0)
        else $error("R9 byte shift left low bits set");
    end
    if (sh == 2'b11) begin
      a_r9_left_fills_lsb: assert (!shift_o[0])
        else $error("R9 left shift left LSB set");
    end
    if (fn == 3'b110 && ctrl_i[2] == 1'b0 && ctrl_i[0] == 1'b0) begin
      a_r4_div_zero_all_ones: assert (neg_o && !zero_o)
        else $error("R4 zero-divisor quotient is not all ones");
    end
    if (fn == 3'b011 && ctrl_i[3:0] == 4'b0000) begin
      a_r6_add_disabled_zero: assert (zero_o)
        else $error("R6 add of two disabled operands is not zero");
    end
    if (zero_o) begin
      a_r12_zero_not_negative: assert (!neg_o)
        else $error("R12 negative flag set on a zero result");
    end
  end
endmodule

bind alu_shift_unit alu_shift_unit_chk #(.WIDTH(WIDTH), .BYTE_SHIFT(BYTE_SHIFT)) u_chk (
  .ctrl_i  (ctrl_i),
  .shift_o (shift_o),
  .zero_o  (zero_o),
  .neg_o   (neg_o)
);

// File: tb/tb_alu_shift_unit.sv
module tb_alu_shift_unit;
  localparam int W = 32;
  localparam logic [W-1:0] MN = 32'h8000_0000;

  logic         clk;
  logic         rst_n;
  logic [8:0]   ctrl;
  logic [W-1:0] opa, opb;
  logic [W-1:0] shift_o;
  logic         zero_o, neg_o;

  typedef struct {
    logic [W-1:0] res;
    logic         z;
    logic         n;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 0;

  alu_shift_unit dut (
    .ctrl_i (ctrl), .opa_i (opa), .opb_i (opb),
    .shift_o(shift_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [8:0] mk(input logic [1:0] sh, input logic [2:0] fn,
                                    input logic ea, input logic eb,
                                    input logic ia, input logic inc);
    return {sh, fn, ea, eb, ia, inc};
  endfunction

  // Reference model written from the requirements
  task automatic model(input logic [8:0] c, input logic [W-1:0] a_in,
                       input logic [W-1:0] b_in, output exp_t e);
    logic [W-1:0] a, b, f, r;
    longint sa, sb;
    a = c[3] ? a_in : '0;
    if (c[1]) a = ~a;
    b = c[2] ? b_in : '0;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (c[6:4])
      3'd0: f = a & b;
      3'd1: f = a | b;
      3'd2: f = ~b;
      3'd3: f = a + b;
      3'd4: f = a ^ b;
      3'd5: f = W'(longint'(a) * longint'(b));
      3'd6: f = (b == 0) ? '1 : W'(sa / sb);
      default: f = (b == 0) ? a : W'(sa % sb);
    endcase
    f = f + W'(c[0]);
    case (c[8:7])
      2'd0: r = f;
      2'd1: r = f >> 1;
      2'd2: r = f << 8;
      default: r = f << 1;
    endcase
    e.res = r;
    e.z   = (f == 0);
    e.n   = f[W-1];
  endtask

  task automatic send(input logic [8:0] c, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    ctrl = c; opa = a; opb = b;
    model(c, a, b, e);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send_exp(input logic [8:0] c, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic [W-1:0] r,
                          input logic z, input logic n, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    ctrl = c; opa = a; opb = b;
    e.res = r; e.z = z; e.n = n; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (shift_o !== e.res || zero_o !== e.z || neg_o !== e.n) begin
        n_fail++;
        $display("FAIL %s: got res=%h z=%b n=%b expected res=%h z=%b n=%b",
                 e.tag, shift_o, zero_o, neg_o, e.res, e.z, e.n);
      end
    end
  end

  function automatic logic [W-1:0] pick(input int k);
    case (k)
      0: return '0;
      1: return '1;
      2: return MN;
      3: return 32'h7FFF_FFFF;
      4: return 32'd1;
      5: return 32'd7;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ctrl = '0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: AND of disabled operands, unshifted
    send_exp(9'd0, '0, '0, '0, 1'b1, 1'b0, "R1 reset state");

    // R1, R10: logic and add functions
    send_exp(mk(0,3'd0,1,1,0,0), 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 0, 0, "R1 R10 AND");
    send_exp(mk(0,3'd1,1,1,0,0), 32'hF000_0000, 32'h0000_000F, 32'hF000_000F, 0, 1, "R1 OR");
    send_exp(mk(0,3'd2,1,1,0,0), 32'hDEAD_BEEF, 32'h0000_FFFF, 32'hFFFF_0000, 0, 1, "R1 NOT B");
    send_exp(mk(0,3'd3,1,1,0,0), 32'd40, 32'd2, 32'd42, 0, 0, "R1 ADD");
    send_exp(mk(0,3'd4,1,1,0,0), 32'hAAAA_AAAA, 32'hFFFF_0000, 32'h5555_AAAA, 0, 0, "R1 XOR");

    // R2: multiply low half
    send_exp(mk(0,3'd5,1,1,0,0), 32'h0001_0001, 32'h0001_0001, 32'h0002_0001, 0, 0, "R2 MUL wrap");
    send_exp(mk(0,3'd5,1,1,0,0), '1, 32'd3, 32'hFFFF_FFFD, 0, 1, "R2 MUL negative");

    // R3: signed divide and remainder
    send_exp(mk(0,3'd6,1,1,0,0), -32'sd7, 32'd2, -32'sd3, 0, 1, "R3 DIV toward zero");
    send_exp(mk(0,3'd7,1,1,0,0), -32'sd7, 32'd2, -32'sd1, 0, 1, "R3 REM dividend sign");
    send_exp(mk(0,3'd7,1,1,0,0), 32'd7, -32'sd2, 32'd1, 0, 0, "R3 REM positive dividend");

    // R4: zero divisor
    send_exp(mk(0,3'd6,1,1,0,0), 32'd99, '0, '1, 0, 1, "R4 DIV by zero");
    send_exp(mk(0,3'd7,1,1,0,0), 32'd99, '0, 32'd99, 0, 0, "R4 REM by zero");

    // R5: overflowing division
    send_exp(mk(0,3'd6,1,1,0,0), MN, '1, MN, 0, 1, "R5 DIV min by -1");
    send_exp(mk(0,3'd7,1,1,0,0), MN, '1, '0, 1, 0, "R5 REM min by -1");

    // R6: enables
    send_exp(mk(0,3'd3,0,1,0,0), 32'd1000, 32'd5, 32'd5, 0, 0, "R6 ENA low passes B");
    send_exp(mk(0,3'd3,1,0,0,0), 32'd1000, 32'd5, 32'd1000, 0, 0, "R6 ENB low passes A");
    send_exp(mk(0,3'd1,0,0,0,0), '1, '1, '0, 1, 0, "R6 both disabled OR");

    // R7: inversion
    send_exp(mk(0,3'd1,1,0,1,0), 32'h0000_00FF, 32'h1234, 32'hFFFF_FF00, 0, 1, "R7 NOT A");
    send_exp(mk(0,3'd3,0,0,1,0), 32'h1234, 32'h1234, '1, 0, 1, "R7 inverted disabled A is -1");

    // R8: increment
    send_exp(mk(0,3'd3,1,1,1,1), 32'd10, 32'd3, -32'sd7, 0, 1, "R8 B minus A");
    send_exp(mk(0,3'd3,1,0,0,1), '1, 32'd8, '0, 1, 0, "R8 increment wraps");
    send_exp(mk(0,3'd0,0,0,0,1), 32'd5, 32'd5, 32'd1, 0, 0, "R8 increment on AND");

    // R9: shift codes
    send_exp(mk(1,3'd3,1,0,0,0), 32'h8000_0003, '0, 32'h4000_0001, 0, 1, "R9 right by 1");
    send_exp(mk(2,3'd3,1,0,0,0), 32'h1234_56AB, '0, 32'h3456_AB00, 0, 0, "R9 left by byte");
    send_exp(mk(3,3'd3,1,0,0,0), 32'h4000_0001, '0, 32'h8000_0002, 0, 0, "R9 left by 1");

    // R11, R12: flags from the unshifted result
    send_exp(mk(3,3'd3,1,0,0,0), MN, '0, '0, 0, 1, "R11 R12 flags before left shift");
    send_exp(mk(1,3'd3,1,0,0,0), 32'd1, '0, '0, 0, 0, "R11 flag before right shift");

    // Random phase: all control words over corner and random operands
    for (int i = 0; i < 2000; i++) begin
      send(9'($urandom), pick($urandom_range(0, 9)), pick($urandom_range(0, 9)),
           "R1 R9 R12 random vector");
    end

    wait (q.size() == 0);
    @(posedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule